// File: doc/BRIEF.md
# Serial Display Command/Data Receiver

This block is the write side of a serial host link for a display controller. The host drives four wires: an active-low select, a serial clock, a serial data line, and a line that marks each byte as either a controller command or pixel data. The receiver assembles bytes with the most significant bit first. It hands each finished byte to a downstream parser as a one-cycle strobe, together with flags that give the byte's type. It also keeps a count of how many parameter bytes the current command still expects. With that count the parser can tell a new command opcode from one of its parameters.

Raising select has two different meanings. If select rises part way through a byte, the transfer is abandoned: the partial byte is thrown away and the bit assembly starts again from nothing. If select rises just after a whole byte, the byte is delivered and the link only pauses. The parameter context survives, so the next session continues where the stream stopped. All link inputs are brought into the system clock domain through two-stage synchronizers, and bits are taken on the rising edge of the serial clock. The link is write only, so the block never drives the serial data line.

Top module: `spi_disp_rx`

## Requirements
- R1: Serial bits are taken on rising serial-clock edges while select is low, most significant bit first. The eighth bit completes a byte, which appears on `byte_data`.
- R2: The data/command line is sampled on the edge that carries the eighth bit. Level 1 marks a frame-memory data byte (`byte_is_data`=1). Level 0 marks a command-stream byte (`byte_is_data`=0). A data byte never has `byte_is_opcode` set.
- R3: If select rises before the eighth bit of a byte, the partial byte is discarded and no strobe is produced for it.
- R4: After a break, the bit position restarts from the first bit. The next eight bits clocked after select falls again form the next byte.
- R5: If select rises directly after a completed byte, that byte is delivered normally, and `params_left` keeps its value across the pause.
- R6: A command-stream byte that arrives while `params_left` is 0 is an opcode (`byte_is_opcode`=1). `params_left` is then loaded with its parameter count: opcodes 0xF0 to 0xF7 take the value of their low three bits, and every other opcode takes 0.
- R7: A command-stream byte that arrives while `params_left` is nonzero is a parameter (`byte_is_opcode`=0), and `params_left` drops by one.
- R8: Data bytes leave `params_left` unchanged.
- R9: A break leaves `params_left` unchanged, so a parameter byte sent again after a break is classified as the same parameter.
- R10: After reset, `byte_vld` is 0 and `params_left` is 0.
- R11: `byte_vld` is high for exactly one system clock cycle per delivered byte. `byte_data`, `byte_is_data`, `byte_is_opcode` and the updated `params_left` are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Link select, active low (asynchronous) |
| sclk | input | 1 | Serial clock, bits taken on rising edge (asynchronous) |
| sdin | input | 1 | Serial data in (asynchronous) |
| dc | input | 1 | Data/command select: 1 data, 0 command stream (asynchronous) |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte value |
| byte_is_data | output | 1 | Byte is frame-memory data |
| byte_is_opcode | output | 1 | Byte is a new command opcode |
| params_left | output | 3 | Parameters still expected by the current command |

## Verification
The assertions take for granted that the serial clock is slow enough for every level to be seen by the synchronizers. Each high and low phase must last at least two system cycles, so that the delivered bytes are always many cycles apart. They also assume that data and the data/command line are stable across each rising serial-clock edge, and that select changes only while the serial clock is low. The stimulus keeps every serial-clock phase at four system cycles. It changes data, the data/command line and select only in the low phase, and it adds several idle cycles around each movement of select.

// File: rtl/sdsp_pkg.sv
package sdsp_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PCNT_W = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              is_data;
    } rx_byte_t;

    // Opcodes 0xF0..0xF7 carry as many parameters as their low three bits.
    function automatic logic [PCNT_W-1:0] param_count(input logic [BYTE_W-1:0] op);
        logic [PCNT_W-1:0] n;
        n = '0;
        if (op[7:3] == 5'b11110) begin
            n = op[PCNT_W-1:0];
        end
        return n;
    endfunction

endpackage

// File: rtl/sdsp_sync.sv
module sdsp_sync #(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/sdsp_shift.sv
module sdsp_shift
    import sdsp_pkg::*;
#(
    parameter int unsigned BW = BYTE_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_s,
    input  logic     sclk_s,
    input  logic     sdin_s,
    input  logic     dc_s,
    output logic     emit,
    output rx_byte_t emit_byte
);

    localparam int unsigned CW = $clog2(BW);

    typedef struct packed {
        logic          sclk_prev;
        logic [CW-1:0] cnt;
        logic [BW-2:0] sh;
        logic          emit;
        rx_byte_t      out;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      rise;

    always_comb begin
        st_d           = st_q;
        st_d.emit      = 1'b0;
        st_d.sclk_prev = sclk_s;
        rise           = sclk_s & ~st_q.sclk_prev;
        if (cs_s) begin
            // select high: any partial byte is dropped
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (rise) begin
            if (st_q.cnt == CW'(BW-1)) begin
                st_d.emit        = 1'b1;
                st_d.out.data    = {st_q.sh, sdin_s};
                st_d.out.is_data = dc_s;
                st_d.cnt         = '0;
            end else begin
                st_d.sh  = {st_q.sh[BW-3:0], sdin_s};
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign emit      = st_q.emit;
    assign emit_byte = st_q.out;

    a_r4_break_resets_count: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (st_q.cnt == '0));

    a_r3_emit_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.emit |-> ($past(!cs_s) && $past(sclk_s)));

endmodule

// File: rtl/sdsp_param.sv
module sdsp_param
    import sdsp_pkg::*;
#(
    parameter int unsigned BW = BYTE_W,
    parameter int unsigned PW = PCNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          emit,
    input  rx_byte_t      emit_byte,
    output logic          vld,
    output logic [BW-1:0] data,
    output logic          is_data,
    output logic          is_op,
    output logic [PW-1:0] left
);

    typedef struct packed {
        logic          vld;
        logic [BW-1:0] data;
        logic          is_data;
        logic          is_op;
        logic [PW-1:0] left;
    } param_st_t;

    param_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (emit) begin
            st_d.vld     = 1'b1;
            st_d.data    = emit_byte.data;
            st_d.is_data = emit_byte.is_data;
            st_d.is_op   = 1'b0;
            if (!emit_byte.is_data) begin
                if (st_q.left == '0) begin
                    st_d.is_op = 1'b1;
                    st_d.left  = param_count(emit_byte.data);
                end else begin
                    st_d.left  = st_q.left - PW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld     = st_q.vld;
    assign data    = st_q.data;
    assign is_data = st_q.is_data;
    assign is_op   = st_q.is_op;
    assign left    = st_q.left;

    a_r7_param_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !emit_byte.is_data && st_q.left != '0) |=>
            (st_q.left == $past(st_q.left) - PW'(1)) && !st_q.is_op);

    a_r6_opcode_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !emit_byte.is_data && st_q.left == '0) |=> (st_q.vld && st_q.is_op));

    a_r8_data_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && emit_byte.is_data) |=> $stable(st_q.left));

    a_r9_idle_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        !emit |=> ($stable(st_q.left) && !st_q.vld));

endmodule

// File: rtl/spi_disp_rx.sv
module spi_disp_rx
    import sdsp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              dc,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_is_data,
    output logic              byte_is_opcode,
    output logic [PCNT_W-1:0] params_left
);

    localparam int unsigned NSIG = 4;

    logic [NSIG-1:0] raw_in, sync_out;
    logic            emit;
    rx_byte_t        emit_byte;

    assign raw_in = {dc, sdin, sclk, cs_n};

    sdsp_sync #(
        .STAGES (SYNC_STAGES),
        .W      (NSIG),
        .RST_VAL(4'b0001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    sdsp_shift #(
        .BW(BYTE_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (sync_out[0]),
        .sclk_s   (sync_out[1]),
        .sdin_s   (sync_out[2]),
        .dc_s     (sync_out[3]),
        .emit     (emit),
        .emit_byte(emit_byte)
    );

    sdsp_param #(
        .BW(BYTE_W),
        .PW(PCNT_W)
    ) u_param (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit     (emit),
        .emit_byte(emit_byte),
        .vld      (byte_vld),
        .data     (byte_data),
        .is_data  (byte_is_data),
        .is_op    (byte_is_opcode),
        .left     (params_left)
    );

    a_r11_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    a_r2_data_not_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_is_data) |-> !byte_is_opcode);

endmodule

// File: tb/sim_spi_disp_rx.sv
module sim_spi_disp_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic       dc = 1'b0;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       byte_is_data;
    logic       byte_is_opcode;
    logic [2:0] params_left;

    always #4 clk = ~clk;

    spi_disp_rx u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .sdin          (sdin),
        .dc            (dc),
        .byte_vld      (byte_vld),
        .byte_data     (byte_data),
        .byte_is_data  (byte_is_data),
        .byte_is_opcode(byte_is_opcode),
        .params_left   (params_left)
    );

    typedef struct {
        logic [7:0] v;
        logic       d;
        logic       op;
        logic [2:0] left;
    } exp_t;

    exp_t exp_q[$];
    int   drv_checks = 0, drv_errs = 0;
    int   mon_checks = 0, mon_errs = 0;
    logic model_left_valid = 1'b1;
    logic [2:0] model_left = 3'd0;
    logic done = 1'b0;
    logic vld_prev = 1'b0;

    function automatic logic [2:0] exp_count(input logic [7:0] op);
        if (op >= 8'hF0 && op <= 8'hF7) return 3'(op - 8'hF0);
        return 3'd0;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] v, input int nbits, input logic dcv);
        for (int i = 0; i < nbits; i++) begin
            sdin = v[7-i];
            dc   = dcv;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
    endtask

    task automatic sel_low();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic sel_high();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic dcv);
        exp_t e;
        e.v = v;
        e.d = dcv;
        if (dcv) begin
            e.op = 1'b0;
        end else if (model_left == 3'd0) begin
            e.op = 1'b1;
            model_left = exp_count(v);
        end else begin
            e.op = 1'b0;
            model_left = model_left - 3'd1;
        end
        e.left = model_left;
        exp_q.push_back(e);
        send_bits(v, 8, dcv);
    endtask

    task automatic check_left(input logic [2:0] expv, input string tag);
        drv_checks++;
        if (params_left !== expv) begin
            drv_errs++;
            $display("FAIL %s params_left actual=%0d expected=%0d", tag, params_left, expv);
        end
    endtask

    // monitor: compare each strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (vld_prev && byte_vld) begin
                mon_checks++;
                mon_errs++;
                $display("FAIL R11 strobe width actual=2+ cycles expected=1");
            end
            if (byte_vld) begin
                exp_t e;
                mon_checks++;
                if (exp_q.size() == 0) begin
                    mon_errs++;
                    $display("FAIL R3 unexpected byte actual=%02h expected=none", byte_data);
                end else begin
                    e = exp_q.pop_front();
                    if (byte_data !== e.v || byte_is_data !== e.d ||
                        byte_is_opcode !== e.op || params_left !== e.left) begin
                        mon_errs++;
                        $display("FAIL R1/R2/R6/R7 byte actual=%02h d%0b op%0b left%0d expected=%02h d%0b op%0b left%0d",
                                 byte_data, byte_is_data, byte_is_opcode, params_left,
                                 e.v, e.d, e.op, e.left);
                    end
                end
            end
            vld_prev <= byte_vld;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", drv_checks + mon_checks + 1, drv_errs + mon_errs + 1);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        // R10: reset state
        drv_checks++;
        if (byte_vld !== 1'b0) begin
            drv_errs++;
            $display("FAIL R10 byte_vld actual=%0b expected=0", byte_vld);
        end
        check_left(3'd0, "R10");
        rst_n = 1'b1;
        wait_clk(6);

        // R1 R2 R8: data bytes, then a pause
        sel_low();
        send_byte(8'hA5, 1'b1);
        send_byte(8'h3C, 1'b1);
        sel_high();
        check_left(3'd0, "R8");

        // R6 R7 R5: opcode with two parameters, pause in between
        sel_low();
        send_byte(8'hF2, 1'b0);
        send_byte(8'h11, 1'b0);
        sel_high();
        check_left(3'd1, "R5");
        sel_low();
        send_byte(8'h22, 1'b0);
        sel_high();
        check_left(3'd0, "R7");

        // R3 R9: break inside a parameter, then resend it
        sel_low();
        send_byte(8'hF3, 1'b0);
        send_byte(8'h44, 1'b0);
        send_bits(8'h55, 5, 1'b0);
        sel_high();
        check_left(3'd2, "R9");
        sel_low();
        send_byte(8'h55, 1'b0);
        send_byte(8'h66, 1'b0);
        sel_high();
        check_left(3'd0, "R9");

        // R4: break in a data byte, then a fresh opcode and data
        sel_low();
        send_bits(8'hFF, 3, 1'b1);
        sel_high();
        sel_low();
        send_byte(8'h2A, 1'b0);
        send_byte(8'h81, 1'b1);
        send_byte(8'h05, 1'b0);
        send_byte(8'h06, 1'b0);
        sel_high();
        check_left(3'd0, "R4");

        // R8: data between an opcode and its parameter
        sel_low();
        send_byte(8'hF1, 1'b0);
        send_byte(8'h99, 1'b1);
        sel_high();
        check_left(3'd1, "R8");
        sel_low();
        send_byte(8'h77, 1'b0);
        sel_high();
        check_left(3'd0, "R7");

        // R7 upper bound: opcode with seven parameters
        sel_low();
        send_byte(8'hF7, 1'b0);
        for (int k = 0; k < 7; k++) begin
            send_byte(8'(8'h10 + k), 1'b0);
        end
        sel_high();
        check_left(3'd0, "R6");

        wait_clk(10);
        // R3: every expected byte arrived, no extra one
        drv_checks++;
        if (exp_q.size() != 0) begin
            drv_errs++;
            $display("FAIL R3 pending bytes actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", drv_checks + mon_checks, drv_errs + mon_errs);
        $finish;
    end

endmodule